// File: doc/BRIEF.md
# Timer Prescaler Reset and Start Synchronization Control

This block is a small control register that lets software restart the prescalers feeding the chip's timers. It holds three live bits: a start-synchronization hold bit and two prescaler restart requests. One request targets the synchronous prescalers clocked by the main clock. The other targets the prescaler of a timer that may run from a separate, asynchronous clock. Writing one to a request bit asserts the matching prescaler reset. The bit then clears itself once the reset has taken effect.

For the synchronous prescalers the reset takes effect at once, so the request lasts one main-clock cycle. When the dedicated timer runs from its asynchronous clock, the request is carried into that clock domain as a level through a synchronizer chain. The level seen there is returned through a second chain. The request bit clears only when that return arrives. While the hold bit is set, neither request bit clears, so every prescaler stays in reset. Software can then arm all timers and release them together by clearing the hold bit.

Top module: `tmr_psc_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and both prescaler reset outputs are low.
- R2: With bit 7 clear, writing a value with bit 0 set makes bit 0 read one and `sync_psc_rst` high on the cycle after the write. Both are low one cycle later.
- R3: With `async_mode` low and bit 7 clear, writing a value with bit 1 set makes bit 1 read one and `tmr2_psc_rst_clk` high for exactly one cycle.
- R4: Bits 6 down to 2 always read zero and ignore writes. Bit 7 reads back the last value written to it.
- R5: While bit 7 is set, bits 0 and 1 stay set once written, and the corresponding reset outputs stay high.
- R6: A write that clears bit 7 clears both pending request bits on the same clock edge. This holds when `async_mode` is low, or when the asynchronous acknowledge has already returned.
- R7: With `async_mode` high, bit 1 stays one for at least two cycles after the write. It clears without further writes within 20 cycles, once the request has crossed to the timer clock and back.
- R8: `tmr2_psc_rst_aclk` follows bit 1 into the `aclk` domain through a `SYNC_STAGES` flop chain. While bit 1 is held, the asynchronous prescaler stays at zero.
- R9: Writing zero to bit 0 or bit 1 never clears a pending request; only the hardware clear rules do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| aclk | input | 1 | Asynchronous timer clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| async_mode | input | 1 | High when the dedicated timer runs from `aclk` |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| sync_psc_rst | output | 1 | Reset for the synchronous prescalers (clk domain) |
| tmr2_psc_rst_clk | output | 1 | Reset for the dedicated prescaler when it runs from clk |
| tmr2_psc_rst_aclk | output | 1 | Reset for the dedicated prescaler in the aclk domain |

## Verification
A write is captured on one rising edge, and the register and the clk-domain resets change on that edge. The bench therefore samples them at the following falling edge. It samples again one edge later to confirm that a one-cycle request has cleared. In asynchronous mode the clear time depends on the phase between the two clocks. The bench checks a fixed lower bound of two cycles. It then polls with a 20-cycle limit, rather than expecting an exact cycle. The `aclk`-side reset is checked through a bench divider that must read zero while the request is held.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int TSM_BIT  = 7;
  localparam int AREQ_BIT = 1;
  localparam int SREQ_BIT = 0;

  // next value of a request bit clocked by clk only
  function automatic logic f_sreq_next(logic set, logic cur, logic hold);
    return set | (cur & hold);
  endfunction

  // next value of the dedicated-timer request bit
  function automatic logic f_areq_next(logic set, logic cur, logic hold,
                                       logic amode, logic ack);
    return set | (cur & (hold | (amode & ~ack)));
  endfunction
endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tpc_xfer.sv
module tpc_xfer #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic aclk,
  input  logic rst_n,
  input  logic req,
  output logic req_aclk,
  output logic ack
);
  tpc_sync #(.STAGES(STAGES)) fwd_i (
    .clk(aclk), .rst_n(rst_n), .d(req), .q(req_aclk)
  );
  tpc_sync #(.STAGES(STAGES)) back_i (
    .clk(clk), .rst_n(rst_n), .d(req_aclk), .q(ack)
  );
endmodule

// File: rtl/tmr_psc_ctrl.sv
module tmr_psc_ctrl
  import tpc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          aclk,
  input  logic          rst_n,
  input  logic          async_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          sync_psc_rst,
  output logic          tmr2_psc_rst_clk,
  output logic          tmr2_psc_rst_aclk
);
  logic tsm_q, sreq_q, areq_q;
  logic tsm_d, sreq_d, areq_d;
  logic set_s, set_a, ack;

  assign set_s = wr_en & wr_data[SREQ_BIT];
  assign set_a = wr_en & wr_data[AREQ_BIT];
  assign tsm_d = wr_en ? wr_data[TSM_BIT] : tsm_q;

  always_comb begin
    sreq_d = f_sreq_next(set_s, sreq_q, tsm_d);
    areq_d = f_areq_next(set_a, areq_q, tsm_d, async_mode, ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsm_q  <= 1'b0;
      sreq_q <= 1'b0;
      areq_q <= 1'b0;
    end else begin
      tsm_q  <= tsm_d;
      sreq_q <= sreq_d;
      areq_q <= areq_d;
    end
  end

  tpc_xfer #(.STAGES(SYNC_STAGES)) xfer_i (
    .clk(clk), .aclk(aclk), .rst_n(rst_n),
    .req(areq_q), .req_aclk(tmr2_psc_rst_aclk), .ack(ack)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[TSM_BIT]  = tsm_q;
    rd_data[AREQ_BIT] = areq_q;
    rd_data[SREQ_BIT] = sreq_q;
  end

  assign sync_psc_rst     = sreq_q;
  assign tmr2_psc_rst_clk = areq_q;

  // R2
  sreq_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sreq_q && !tsm_q && !wr_en) |=> !sync_psc_rst);
  // R3
  areq_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (areq_q && !tsm_q && !async_mode && !wr_en) |=> !tmr2_psc_rst_clk);
  // R4
  ro_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[TSM_BIT-1:AREQ_BIT+1] == '0);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsm_q && sreq_q && !wr_en) |=> sync_psc_rst);
  // R7
  async_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (areq_q && async_mode && !ack && !wr_en) |=> tmr2_psc_rst_clk);
endmodule

// File: tb/tmr_psc_ctrl_tb_top.sv
module tmr_psc_ctrl_tb_top;
  logic clk = 1'b0, aclk = 1'b0, rst_n = 1'b0;
  logic async_mode = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic sync_psc_rst, tmr2_psc_rst_clk, tmr2_psc_rst_aclk;
  int tests = 0, fails = 0;
  logic [7:0] adiv;

  always #10 clk = ~clk;
  always #7  aclk = ~aclk;

  // bench model of the dedicated prescaler on aclk
  always_ff @(posedge aclk or negedge rst_n)
    if (!rst_n)                 adiv <= '0;
    else if (tmr2_psc_rst_aclk) adiv <= '0;
    else                        adiv <= adiv + 8'd1;

  tmr_psc_ctrl dut_i (
    .clk(clk), .aclk(aclk), .rst_n(rst_n), .async_mode(async_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sync_psc_rst(sync_psc_rst), .tmr2_psc_rst_clk(tmr2_psc_rst_clk),
    .tmr2_psc_rst_aclk(tmr2_psc_rst_aclk)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk(rd_data == 8'h00, "R1", rd_data, 0);
    chk({sync_psc_rst, tmr2_psc_rst_clk, tmr2_psc_rst_aclk} == 3'b000, "R1",
        {sync_psc_rst, tmr2_psc_rst_clk, tmr2_psc_rst_aclk}, 0);
  endtask

  task automatic t_sync_pulse();
    wr(8'h01);
    chk(rd_data == 8'h01 && sync_psc_rst, "R2", rd_data, 1);
    @(negedge clk);
    chk(rd_data == 8'h00 && !sync_psc_rst, "R2", rd_data, 0);
  endtask

  task automatic t_clk_mode_async_bit();
    async_mode = 1'b0;
    wr(8'h02);
    chk(rd_data == 8'h02 && tmr2_psc_rst_clk, "R3", rd_data, 2);
    @(negedge clk);
    chk(rd_data == 8'h00 && !tmr2_psc_rst_clk, "R3", rd_data, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_readonly();
    wr(8'h7C);
    chk(rd_data == 8'h00, "R4", rd_data, 0);
    wr(8'h80);
    chk(rd_data == 8'h80, "R4", rd_data, 8'h80);
    wr(8'h00);
    chk(rd_data == 8'h00, "R4", rd_data, 0);
  endtask

  task automatic t_hold_release();
    async_mode = 1'b0;
    wr(8'h83);
    repeat (10) @(negedge clk);
    chk(rd_data == 8'h83 && sync_psc_rst && tmr2_psc_rst_clk, "R5", rd_data, 8'h83);
    wr(8'h80);
    chk(rd_data == 8'h83, "R9", rd_data, 8'h83);
    wr(8'h00);
    chk(rd_data == 8'h00 && !sync_psc_rst && !tmr2_psc_rst_clk, "R6", rd_data, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_async_handshake();
    int n;
    logic seen;
    async_mode = 1'b1;
    wr(8'h02);
    chk(rd_data[1] == 1'b1, "R7", rd_data, 2);
    @(negedge clk);
    chk(rd_data[1] == 1'b1, "R7", rd_data, 2);
    n = 0;
    seen = 1'b0;
    while (rd_data[1] && n < 20) begin
      @(negedge clk);
      seen |= tmr2_psc_rst_aclk;
      n++;
    end
    chk(rd_data[1] == 1'b0, "R7", rd_data, 0);
    chk(seen, "R8", seen, 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_async_hold();
    int n;
    async_mode = 1'b1;
    wr(8'h83);
    repeat (20) @(negedge clk);
    chk(rd_data == 8'h83 && tmr2_psc_rst_aclk, "R5", rd_data, 8'h83);
    chk(adiv == 8'h00, "R8", adiv, 0);
    wr(8'h00);
    chk(rd_data == 8'h00, "R6", rd_data, 0);
    n = 0;
    while (tmr2_psc_rst_aclk && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(!tmr2_psc_rst_aclk, "R8", tmr2_psc_rst_aclk, 0);
    repeat (4) @(negedge clk);
    chk(adiv != 8'h00, "R8", adiv, 1);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_pulse();
    t_clk_mode_async_bit();
    t_readonly();
    t_hold_release();
    t_async_handshake();
    t_async_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule